// File: doc/BRIEF.md
# Dual-Mode SPI Bit-Clock Divider

This block derives the serial bit clock of an SPI master from the module clock. A single clock-rate configuration word picks one of two divider schemes. The exponential scheme divides by a power of two. The linear scheme divides by an even number set by an 8-bit field. Whichever scheme is in use, the overall division is never below two. The block produces the 50% duty serial clock level together with one-cycle strobes that mark every level change, split into leading-to-high and high-to-low strobes, so the data shifter can launch and capture bits without looking at the clock level itself.

Software works out the best divider setting and writes the configuration word. The shifter raises `run` for the length of a transfer. While `run` is low the divider is idle: the serial clock rests at the polarity level given on `cpol`, and the counter is held clear. A configuration change made during a transfer never cuts a clock period short. It is taken up at the next point where the serial clock returns to its rest level, or at once when the divider is idle.

Top module: `spi_clk_divider`

## Requirements
- R1: Bit 12 of `rate_cfg` selects the scheme. With 0 the exponent field `rate_cfg[11:8]` is used and `rate_cfg[7:0]` is ignored. With 1 the linear field `rate_cfg[7:0]` is used and `rate_cfg[11:8]` is ignored.
- R2: In exponential mode with exponent E from 1 to 15, one serial clock period is 2^E module clocks, and `sclk_toggle` pulses every 2^(E-1) cycles.
- R3: In exponential mode E = 0 gives division by two: `sclk_toggle` is high on every cycle of a transfer, and `sclk_rise` never pulses on two cycles in a row.
- R4: In linear mode with field value N, one serial clock period is 2*(N+1) module clocks, and `sclk_toggle` pulses every N+1 cycles.
- R5: `sclk` changes level on the clock edge that ends each cycle in which `sclk_toggle` is high, and on no other edge during a transfer. Both half periods are equal, which gives 50% duty. The first pulse of `sclk_toggle` comes in the last cycle of the first half period after `run` rises.
- R6: `sclk_rise` pulses with `sclk_toggle` when `sclk` is low and about to go high. `sclk_fall` pulses with `sclk_toggle` when `sclk` is high and about to go low. The first edge of a transfer moves `sclk` away from the `cpol` level.
- R7: When `run` is low, `sclk` takes the `cpol` level on the next clock edge, no strobe pulses, and the next transfer starts a full half period from count zero.
- R8: A change of `rate_cfg` during a transfer takes effect only after the period in progress has ended, that is, at the edge where `sclk` returns to `cpol`. While the divider is idle a change takes effect at once.
- R9: After synchronous reset (`rst_n` low at a clock edge) `sclk` equals `cpol` and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run | input | 1 | High for the length of a transfer; low holds the divider idle |
| cpol | input | 1 | Idle level of the serial clock |
| rate_cfg | input | 13 | Clock-rate word: bit 12 selects the scheme, 11:8 is the exponent, 7:0 is the linear count |
| sclk | output | 1 | Serial clock level |
| sclk_toggle | output | 1 | One-cycle strobe: `sclk` changes on the next edge |
| sclk_rise | output | 1 | One-cycle strobe: `sclk` goes from low to high on the next edge |
| sclk_fall | output | 1 | One-cycle strobe: `sclk` goes from high to low on the next edge |

## Verification
All sixteen exponent values are swept in exponential mode, with garbage written into the unused linear field. This separates a wrong shift amount, a missing special case for exponent zero, and leakage between the two fields. Linear mode is swept over every count from 0 to 31 and at 127 and 255, with garbage in the exponent field. This shows whether the period is N+1 or N per half and whether the field is decoded to its full width. Both polarities alternate across the sweeps, so an edge strobe tied to the wrong level or a rest level that ignores `cpol` shows up. Dedicated runs change the word in the first half and in the second half of a period. These tell a divider that reloads at the period boundary apart from one that reloads at every level change or at once.

// File: rtl/spi_clkdiv_pkg.sv
// Package: shared widths, field positions and the divider-scheme type for
// the SPI bit-clock divider. Assumes the exponent field sits directly above
// the linear field and the scheme select bit sits directly above both.
package spi_clkdiv_pkg;

    // Default field widths of the clock-rate word.
    localparam int DEF_EXP_W = 4;
    localparam int DEF_LIN_W = 8;

    // Divider scheme chosen by the select bit.
    typedef enum logic {
        DIV_POW2   = 1'b0,
        DIV_LINEAR = 1'b1
    } div_scheme_e;

    // Width needed to hold (half period - 1) for either scheme.
    // Exponential: the largest half period is 2^(2^EXP_W - 2), so its
    // value minus one needs 2^EXP_W - 2 bits. Linear: the count itself.
    function automatic int half_width(input int exp_w, input int lin_w);
        int pow_w;
        pow_w = (1 << exp_w) - 2;
        if (pow_w < 1) pow_w = 1;
        return (pow_w > lin_w) ? pow_w : lin_w;
    endfunction

endpackage

// File: rtl/spi_rate_decode.sv
// Module: spi_rate_decode
// Turns the clock-rate word into the number of module clocks per half
// period, minus one. Purely combinational. Assumes HALF_W comes from
// spi_clkdiv_pkg::half_width so that every legal setting fits.
module spi_rate_decode
    import spi_clkdiv_pkg::*;
#(
    parameter int EXP_W  = DEF_EXP_W,
    parameter int LIN_W  = DEF_LIN_W,
    parameter int HALF_W = half_width(DEF_EXP_W, DEF_LIN_W),
    localparam int CFG_W = EXP_W + LIN_W + 1
) (
    input  logic [CFG_W-1:0]  cfg,
    output logic [HALF_W-1:0] half_m1
);

    localparam int SEL_POS = EXP_W + LIN_W;

    div_scheme_e          scheme;
    logic [EXP_W-1:0]     exp_f;
    logic [LIN_W-1:0]     lin_f;
    logic [HALF_W:0]      pow_one_hot;
    logic [HALF_W-1:0]    pow_half_m1;
    logic [HALF_W-1:0]    lin_half_m1;

    // Split the word into its select bit and the two fields.
    always_comb begin
        scheme = div_scheme_e'(cfg[SEL_POS]);
        exp_f  = cfg[SEL_POS-1 -: EXP_W];
        lin_f  = cfg[LIN_W-1:0];
    end

    // Exponential half period minus one: 2^(E-1) - 1, and E = 0 folds to 0
    // so that the smallest division stays at two.
    always_comb begin
        pow_one_hot = '0;
        for (int k = 1; k < (1 << EXP_W); k++) begin
            if (int'(exp_f) == k) pow_one_hot[k-1] = 1'b1;
        end
        if (exp_f == '0) pow_one_hot[0] = 1'b1;
        pow_half_m1 = HALF_W'(pow_one_hot - 1'b1);
    end

    // Linear half period minus one is the field itself.
    always_comb begin
        lin_half_m1 = HALF_W'(lin_f);
    end

    // Scheme select.
    always_comb begin
        half_m1 = (scheme == DIV_LINEAR) ? lin_half_m1 : pow_half_m1;
    end

endmodule

// File: rtl/spi_half_counter.sv
// Module: spi_half_counter
// Counts module clocks inside one half period of the serial clock and
// flags the last cycle of it. Held at zero while idle. Assumes half_m1 is
// stable during a half period (the top only reloads it at a period end).
module spi_half_counter #(
    parameter int HALF_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [HALF_W-1:0] half_m1,
    output logic              last_cycle
);

    logic [HALF_W-1:0] cnt_q;

    // Terminal count: the current cycle closes a half period.
    always_comb begin
        last_cycle = (cnt_q == half_m1);
    end

    // Half-period counter: clear while idle or on wrap, otherwise advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || last_cycle) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/spi_sclk_phase.sv
// Module: spi_sclk_phase
// Holds the serial clock level, flips it at each half-period end and
// derives the edge strobes and the full-period boundary. Assumes cpol is
// stable while run is high.
module spi_sclk_phase (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic cpol,
    input  logic last_cycle,
    output logic sclk,
    output logic toggle,
    output logic rise,
    output logic fall,
    output logic period_end
);

    logic sclk_q;

    // Strobes: a level change is due only while a transfer runs.
    always_comb begin
        toggle     = run && last_cycle;
        rise       = toggle && !sclk_q;
        fall       = toggle && sclk_q;
        period_end = toggle && (sclk_q != cpol);
        sclk       = sclk_q;
    end

    // Serial clock level: rest at cpol when idle, flip on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= cpol;
        end else if (!run) begin
            sclk_q <= cpol;
        end else if (toggle) begin
            sclk_q <= ~sclk_q;
        end
    end

endmodule

// File: rtl/spi_clk_divider.sv
// Module: spi_clk_divider (top)
// SPI bit-clock divider with exponential and linear schemes. The decoded
// half period is latched and only replaced while idle or at the edge where
// the serial clock returns to its rest level, so no period is shortened.
// Assumes rate_cfg comes from a register in the module clock domain.
module spi_clk_divider
    import spi_clkdiv_pkg::*;
#(
    parameter int EXP_W = DEF_EXP_W,
    parameter int LIN_W = DEF_LIN_W,
    localparam int CFG_W  = EXP_W + LIN_W + 1,
    localparam int HALF_W = half_width(EXP_W, LIN_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             cpol,
    input  logic [CFG_W-1:0] rate_cfg,
    output logic             sclk,
    output logic             sclk_toggle,
    output logic             sclk_rise,
    output logic             sclk_fall
);

    logic [HALF_W-1:0] dec_half_m1;
    logic [HALF_W-1:0] half_q;
    logic              last_cycle;
    logic              period_end;

    spi_rate_decode #(
        .EXP_W  (EXP_W),
        .LIN_W  (LIN_W),
        .HALF_W (HALF_W)
    ) i_decode (
        .cfg     (rate_cfg),
        .half_m1 (dec_half_m1)
    );

    // Active half period: reload while idle or at a full-period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q <= '0;
        end else if (!run || period_end) begin
            half_q <= dec_half_m1;
        end
    end

    spi_half_counter #(
        .HALF_W (HALF_W)
    ) i_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .half_m1    (half_q),
        .last_cycle (last_cycle)
    );

    spi_sclk_phase i_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .cpol       (cpol),
        .last_cycle (last_cycle),
        .sclk       (sclk),
        .toggle     (sclk_toggle),
        .rise       (sclk_rise),
        .fall       (sclk_fall),
        .period_end (period_end)
    );

endmodule

// File: rtl/spi_clk_divider_checker.sv
// Module: spi_clk_divider_checker
// Temporal checks on the divider's ports and its latched half period.
// Attached to every instance of spi_clk_divider by the bind below.
module spi_clk_divider_checker #(
    parameter int HALF_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              cpol,
    input logic              sclk,
    input logic              sclk_toggle,
    input logic              sclk_rise,
    input logic              sclk_fall,
    input logic [HALF_W-1:0] half_q
);

    // R7: idle drives the clock to the rest level on the next edge.
    p_idle_rest_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (sclk == $past(cpol)));

    // R7: no strobe while idle.
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !(sclk_toggle || sclk_rise || sclk_fall));

    // R5: a strobe in a transfer is followed by a level change.
    p_edge_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && sclk_toggle) |=> (sclk != $past(sclk)));

    // R5: without a strobe the level holds during a transfer.
    p_level_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !sclk_toggle) |=> $stable(sclk));

    // R6: a rising strobe leaves the clock high, a falling one low.
    p_rise_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_rise |=> sclk);
    p_fall_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_fall |=> !sclk);

    // R3: two rising edges are at least one full period of two cycles apart.
    p_min_div_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_rise |=> !sclk_rise);

    // R8: the active half period moves only at a period boundary in a transfer.
    p_reload_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !(sclk_toggle && (sclk != cpol))) |=> $stable(half_q));

endmodule

bind spi_clk_divider spi_clk_divider_checker #(
    .HALF_W (HALF_W)
) i_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .cpol        (cpol),
    .sclk        (sclk),
    .sclk_toggle (sclk_toggle),
    .sclk_rise   (sclk_rise),
    .sclk_fall   (sclk_fall),
    .half_q      (half_q)
);

// File: tb/test_spi_clk_divider.sv
// Bench: sweeps both divider schemes, checks every sample of each run
// against an arithmetic model, and covers reload timing and idle state.
module test_spi_clk_divider;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        cpol = 1'b0;
    logic [12:0] rate_cfg = '0;
    logic        sclk, sclk_toggle, sclk_rise, sclk_fall;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    spi_clk_divider i_spi_clk_divider (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .cpol        (cpol),
        .rate_cfg    (rate_cfg),
        .sclk        (sclk),
        .sclk_toggle (sclk_toggle),
        .sclk_rise   (sclk_rise),
        .sclk_fall   (sclk_fall)
    );

    // Half period in module clocks, from R1, R2, R3, R4.
    function automatic int half_of(input logic [12:0] c);
        if (c[12]) return int'(c[7:0]) + 1;
        if (c[11:8] == 4'd0) return 1;
        return 1 << (int'(c[11:8]) - 1);
    endfunction

    // One transfer of nsamp cycles, optional word change after sample chg.
    task automatic run_case(input logic [12:0] c0, input logic [12:0] c1,
                            input int chg, input logic pol, input int nsamp,
                            input string tag);
        int ch, pc, bad;
        logic sx, tx;
        logic [12:0] cur;
        @(negedge clk);
        rate_cfg = c0; cpol = pol; run = 1'b0;
        @(negedge clk);
        @(negedge clk);
        run = 1'b1;
        #1;
        cur = c0; ch = half_of(c0); pc = 0; sx = pol; bad = 0;
        for (int i = 0; i < nsamp; i++) begin
            if (i > 0) begin
                @(negedge clk);
                #1;
            end
            tx = (pc == ch - 1);
            if (bad == 0 && (sclk !== sx || sclk_toggle !== tx ||
                sclk_rise !== (tx && !sx) || sclk_fall !== (tx && sx))) begin
                bad = 1;
                $display("FAIL %s cfg=%h sample %0d: sclk/tog/rise/fall=%b%b%b%b expected %b%b%b%b",
                         tag, c0, i, sclk, sclk_toggle, sclk_rise, sclk_fall,
                         sx, tx, tx && !sx, tx && sx);
            end
            if (i == chg) begin
                cur = c1;
                rate_cfg = c1;
            end
            if (tx) begin
                pc = 0;
                sx = ~sx;
                if (sx == pol) ch = half_of(cur);
            end else begin
                pc++;
            end
        end
        checks++;
        if (bad != 0) fails++;
        // R7: stop, then the clock rests at cpol with no strobe.
        @(negedge clk);
        run = 1'b0;
        @(negedge clk);
        #1;
        checks++;
        if (sclk !== pol || sclk_toggle !== 1'b0 || sclk_rise !== 1'b0 || sclk_fall !== 1'b0) begin
            fails++;
            $display("FAIL R7 idle after %s: sclk/tog/rise/fall=%b%b%b%b expected %b000",
                     tag, sclk, sclk_toggle, sclk_rise, sclk_fall, pol);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(8 * 195000);
        fails++;
        $display("FAIL watchdog expired: actual hung, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R9: reset state with cpol high.
        cpol = 1'b1;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        checks++;
        if (sclk !== 1'b1 || sclk_toggle !== 1'b0 || sclk_rise !== 1'b0 || sclk_fall !== 1'b0) begin
            fails++;
            $display("FAIL R9 reset: sclk/tog/rise/fall=%b%b%b%b expected 1000",
                     sclk, sclk_toggle, sclk_rise, sclk_fall);
        end
        rst_n = 1'b1;

        // R1, R2, R3: exponential sweep, junk in the linear field.
        for (int e = 0; e < 16; e++) begin
            automatic logic [12:0] c = {1'b0, 4'(e), 8'hA5 ^ 8'(e)};
            automatic int h = half_of(c);
            run_case(c, c, -1, 1'(e), (e <= 12) ? 4 * h + 3 : 2 * h + 2,
                     (e == 0) ? "R3 pow2 e0" : "R2 R1 pow2");
        end

        // R1, R4, R6: linear sweep, junk in the exponent field.
        for (int n = 0; n < 32; n++) begin
            automatic logic [12:0] c = {1'b1, 4'(15 - (n % 16)), 8'(n)};
            run_case(c, c, -1, 1'(n >> 1), 4 * (n + 1) + 3, "R4 R6 R1 linear");
        end
        run_case({1'b1, 4'hF, 8'd127}, {1'b1, 4'hF, 8'd127}, -1, 1'b0, 520, "R4 linear 127");
        run_case({1'b1, 4'h0, 8'd255}, {1'b1, 4'h0, 8'd255}, -1, 1'b1, 1030, "R4 linear 255");

        // R8: change in first half, in second half, and to a longer period.
        run_case({1'b1, 4'h0, 8'd3}, {1'b1, 4'h0, 8'd1}, 2, 1'b0, 24, "R8 first half");
        run_case({1'b1, 4'h0, 8'd3}, {1'b1, 4'h0, 8'd1}, 5, 1'b1, 24, "R8 second half");
        run_case({1'b0, 4'h1, 8'h00}, {1'b1, 4'h0, 8'd4}, 0, 1'b0, 30, "R8 grow");
        run_case({1'b1, 4'h0, 8'd2}, {1'b0, 4'h0, 8'h33}, 6, 1'b1, 20, "R8 boundary hit");

        // R5: duty checked inside every run above; long exponent repeat.
        run_case({1'b0, 4'h5, 8'hFF}, {1'b0, 4'h5, 8'hFF}, -1, 1'b0, 200, "R5 duty");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule